// File: doc/BRIEF.md
# Shared-Memory Doorbell and Interrupt Register Block

This block is the small control register window of a device that lets several virtual machines share one memory region. Software reaches it through a 32-bit request/response register port with a size qualifier on every access. It keeps an interrupt enable word and an interrupt cause word, and drives one level-sensitive interrupt line from them. It also reports the local machine number and forwards doorbell writes to an external router.

A separate event channel delivers one byte at a time from other machines. Each byte replaces the cause word. Software reads the cause word to learn why it was interrupted, and that read also acknowledges the interrupt by clearing the word. A word written to the doorbell offset is not interpreted here. It leaves the block as a one-cycle strobe that carries the written data.

Top module: `shm_irq_regs`

## Requirements
- R1: Register offsets are enable at 0x00, cause at 0x04, identity at 0x08 and doorbell at 0x0C. Every read request is answered with `rsp_valid` high for exactly the following cycle, and `rsp_rdata` holds the value in that cycle.
- R2: For writes, address bits [1:0] are disregarded, so a word write to 0x07 updates the cause word.
- R3: `irq` is high exactly when the bitwise AND of the cause and enable words is non-zero. It follows every update on the clock edge that performs the update.
- R4: A word write to the enable or cause offset replaces all 32 bits of that word.
- R5: A word read at 0x04 returns the cause word and clears it to zero on the same edge, which lowers `irq`.
- R6: `req_size` is coded 0 for byte, 1 for 16-bit and 2 for 32-bit. Byte and 16-bit writes change nothing, including the doorbell. Byte and 16-bit reads return zero and have no side effect.
- R7: A word read at 0x08 returns `local_id`, zero-extended, while `shm_mapped` is high, and 0xFFFFFFFF while it is low.
- R8: A word read at any other address, including 0x0C and unaligned forms of the decoded offsets, returns zero.
- R9: An event (`evt_valid` high) overwrites the cause word with `evt_data`, zero-extended to 32 bits.
- R10: When an event arrives in the same cycle as a cause read-clear or a cause write, the event value is what the cause word holds afterwards.
- R11: Reset clears the cause word, so `irq` is low after reset. The enable word keeps the value it had before reset.
- R12: A word write whose address, with bits [1:0] disregarded, is 0x0C raises `bell_valid` for exactly the next cycle, with `bell_data` equal to the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| req_addr | input | ADDR_W (8) | Byte address inside the 256-byte window |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after the read |
| rsp_rdata | output | DATA_W (32) | Read response data |
| evt_valid | input | 1 | Incoming event strobe |
| evt_data | input | EVT_W (8) | Incoming event value |
| shm_mapped | input | 1 | Shared region is mapped |
| local_id | input | ID_W (16) | Local machine number |
| irq | output | 1 | Level interrupt |
| bell_valid | output | 1 | Doorbell strobe to the router |
| bell_data | output | DATA_W (32) | Doorbell payload |

## Verification
On every cycle, the assertions check the following: the read response timing, the fact that narrow accesses produce neither a doorbell nor non-zero read data, the all-ones identity value while the region is unmapped, the interrupt dropping after a cause read-clear with no event, and a quiet state after reset. Other behaviours need the bench's scenarios and its per-clock reference model. These are the enable word keeping its value across reset, the event winning a collision with a read-clear or a write, the dropping of address bits [1:0] on writes but not on reads, and the exact payload of a doorbell.

// File: rtl/shm_regs_pkg.sv
package shm_regs_pkg;

   localparam int OFF_ENABLE = 'h00;
   localparam int OFF_CAUSE  = 'h04;
   localparam int OFF_IDENT  = 'h08;
   localparam int OFF_BELL   = 'h0C;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic wr_enable;
      logic wr_cause;
      logic wr_bell;
      logic rd_enable;
      logic rd_cause;
      logic rd_ident;
      logic rd_any;
   } acc_strobe_t;

endpackage

// File: rtl/shm_access_decode.sv
module shm_access_decode
   import shm_regs_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   output acc_strobe_t       acc
);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFF_CAUSE);
   localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFF_IDENT);
   localparam logic [ADDR_W-1:0] A_BELL   = ADDR_W'(OFF_BELL);

   logic              is_word;
   logic              wr_ok;
   logic              rd_ok;
   logic [ADDR_W-1:0] wr_addr;

   always_comb begin
      is_word = (acc_size_e'(req_size) == SZ_WORD);
      wr_ok   = req_valid &&  req_write && is_word;
      rd_ok   = req_valid && !req_write && is_word;
      wr_addr = {req_addr[ADDR_W-1:2], 2'b00};

      acc.wr_enable = wr_ok && (wr_addr == A_ENABLE);
      acc.wr_cause  = wr_ok && (wr_addr == A_CAUSE);
      acc.wr_bell   = wr_ok && (wr_addr == A_BELL);
      acc.rd_enable = rd_ok && (req_addr == A_ENABLE);
      acc.rd_cause  = rd_ok && (req_addr == A_CAUSE);
      acc.rd_ident  = rd_ok && (req_addr == A_IDENT);
      acc.rd_any    = req_valid && !req_write;
   end
endmodule

// File: rtl/shm_irq_state.sv
module shm_irq_state
   import shm_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int EVT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  acc_strobe_t       acc,
   input  logic [DATA_W-1:0] wdata,
   input  logic              evt_valid,
   input  logic [EVT_W-1:0]  evt_data,
   output logic [DATA_W-1:0] enable_q,
   output logic [DATA_W-1:0] cause_q,
   output logic              irq
);
   localparam int PAD_W = DATA_W - EVT_W;

   logic [DATA_W-1:0] evt_word;

   generate
      if (PAD_W > 0) begin : g_evt_pad
         assign evt_word = {{PAD_W{1'b0}}, evt_data};
      end else begin : g_evt_full
         assign evt_word = evt_data[DATA_W-1:0];
      end
   endgenerate

   // enable word deliberately has no reset
   always_ff @(posedge clk) begin
      if (acc.wr_enable) enable_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)                cause_q <= '0;
      else if (evt_valid)     cause_q <= evt_word;
      else if (acc.rd_cause)  cause_q <= '0;
      else if (acc.wr_cause)  cause_q <= wdata;
   end

   assign irq = |(cause_q & enable_q);
endmodule

// File: rtl/shm_read_port.sv
module shm_read_port
   import shm_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ID_W   = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  acc_strobe_t       acc,
   input  logic [DATA_W-1:0] enable_q,
   input  logic [DATA_W-1:0] cause_q,
   input  logic              shm_mapped,
   input  logic [ID_W-1:0]   local_id,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int ID_PAD = DATA_W - ID_W;

   logic [DATA_W-1:0] id_word;
   logic [DATA_W-1:0] sel;

   generate
      if (ID_PAD > 0) begin : g_id_pad
         assign id_word = {{ID_PAD{1'b0}}, local_id};
      end else begin : g_id_full
         assign id_word = local_id[DATA_W-1:0];
      end
   endgenerate

   always_comb begin
      sel = '0;
      if (acc.rd_enable) sel = enable_q;
      if (acc.rd_cause)  sel = cause_q;
      if (acc.rd_ident)  sel = shm_mapped ? id_word : '1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc.rd_any;
         if (acc.rd_any) rsp_rdata <= sel;
      end
   end
endmodule

// File: rtl/shm_bell_port.sv
module shm_bell_port
   import shm_regs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  acc_strobe_t       acc,
   input  logic [DATA_W-1:0] wdata,
   output logic              bell_valid,
   output logic [DATA_W-1:0] bell_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         bell_valid <= 1'b0;
         bell_data  <= '0;
      end else begin
         bell_valid <= acc.wr_bell;
         if (acc.wr_bell) bell_data <= wdata;
      end
   end
endmodule

// File: rtl/shm_irq_regs.sv
module shm_irq_regs
   import shm_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int EVT_W  = 8,
   parameter int ID_W   = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              evt_valid,
   input  logic [EVT_W-1:0]  evt_data,
   input  logic              shm_mapped,
   input  logic [ID_W-1:0]   local_id,
   output logic              irq,
   output logic              bell_valid,
   output logic [DATA_W-1:0] bell_data
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("shm_irq_regs: DATA_W must be 32 for a 4-byte register stride");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("shm_irq_regs: ADDR_W too small for the register window");
      end
      if (EVT_W > DATA_W || ID_W > DATA_W) begin : g_bad_width
         $error("shm_irq_regs: EVT_W and ID_W must not exceed DATA_W");
      end
   endgenerate

   acc_strobe_t       acc;
   logic [DATA_W-1:0] enable_q;
   logic [DATA_W-1:0] cause_q;

   shm_access_decode #(.ADDR_W(ADDR_W)) u_decode (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_size  (req_size),
      .req_addr  (req_addr),
      .acc       (acc)
   );

   shm_irq_state #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_state (
      .clk       (clk),
      .rst       (rst),
      .acc       (acc),
      .wdata     (req_wdata),
      .evt_valid (evt_valid),
      .evt_data  (evt_data),
      .enable_q  (enable_q),
      .cause_q   (cause_q),
      .irq       (irq)
   );

   shm_read_port #(.DATA_W(DATA_W), .ID_W(ID_W)) u_read (
      .clk        (clk),
      .rst        (rst),
      .acc        (acc),
      .enable_q   (enable_q),
      .cause_q    (cause_q),
      .shm_mapped (shm_mapped),
      .local_id   (local_id),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

   shm_bell_port #(.DATA_W(DATA_W)) u_bell (
      .clk        (clk),
      .rst        (rst),
      .acc        (acc),
      .wdata      (req_wdata),
      .bell_valid (bell_valid),
      .bell_data  (bell_data)
   );
endmodule

// File: rtl/shm_irq_regs_chk.sv
module shm_irq_regs_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int EVT_W  = 8,
   parameter int ID_W   = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              evt_valid,
   input logic [EVT_W-1:0]  evt_data,
   input logic              shm_mapped,
   input logic [ID_W-1:0]   local_id,
   input logic              irq,
   input logic              bell_valid,
   input logic [DATA_W-1:0] bell_data
);
   logic is_word, rd_w, wr_w, narrow;
   logic [ADDR_W-1:0] wa;
   always_comb begin
      is_word = (req_size == 2'd2);
      rd_w    = req_valid && !req_write && is_word;
      wr_w    = req_valid &&  req_write && is_word;
      narrow  = req_valid && !is_word;
      wa      = {req_addr[ADDR_W-1:2], 2'b00};
   end

   AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (rsp_valid == $past(req_valid && !req_write))); // R1

   AST_BELL_SOURCE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && bell_valid) |->
         ($past(wr_w && wa == ADDR_W'('h0C)) && bell_data == $past(req_wdata))); // R12

   AST_NARROW_NO_BELL: assert property (@(posedge clk) disable iff (rst)
      (narrow && req_write) |=> !bell_valid); // R6

   AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      (narrow && !req_write) |=> (rsp_rdata == '0)); // R6

   AST_IDENT_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
      (rd_w && req_addr == ADDR_W'('h08) && !shm_mapped) |=> (rsp_rdata == '1)); // R7

   AST_CAUSE_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
      (rd_w && req_addr == ADDR_W'('h04) && !evt_valid) |=> !irq); // R5

   AST_ZERO_EVENT_QUIET: assert property (@(posedge clk) disable iff (rst)
      (evt_valid && evt_data == '0) |=> !irq); // R9

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!irq && !bell_valid && !rsp_valid)); // R11
endmodule

bind shm_irq_regs shm_irq_regs_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_W(EVT_W), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_valid(evt_valid),
   .evt_data(evt_data), .shm_mapped(shm_mapped), .local_id(local_id),
   .irq(irq), .bell_valid(bell_valid), .bell_data(bell_data)
);

// File: tb/test_shm_irq_regs.sv
`timescale 1ns/1ps
module test_shm_irq_regs;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        evt_valid = 1'b0;
   logic [7:0]  evt_data = '0;
   logic        shm_mapped = 1'b0;
   logic [15:0] local_id = '0;
   logic        irq;
   logic        bell_valid;
   logic [31:0] bell_data;

   always #5 clk = ~clk;

   shm_irq_regs i_shm_irq_regs (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_valid(evt_valid),
      .evt_data(evt_data), .shm_mapped(shm_mapped), .local_id(local_id),
      .irq(irq), .bell_valid(bell_valid), .bell_data(bell_data)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string tag = "R11";

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   logic [31:0] m_enable = '0;
   logic [31:0] m_cause  = '0;
   logic        m_rsp_v  = 1'b0;
   logic [31:0] m_rdata  = '0;
   logic        m_bell_v = 1'b0;
   logic [31:0] m_bell_d = '0;
   bit          live = 0;

   always @(posedge clk) begin
      logic [31:0] nxt;
      logic        word;
      word = (req_size == 2'd2);
      if (rst) begin
         m_cause = '0; m_rsp_v = 0; m_bell_v = 0;
      end else begin
         live = 1;
         nxt = m_cause;
         m_rsp_v = req_valid && !req_write;
         m_bell_v = 0;
         if (req_valid && !req_write) begin
            m_rdata = 0;
            if (word) begin
               case (req_addr)
                  8'h00: m_rdata = m_enable;
                  8'h04: begin m_rdata = m_cause; nxt = 0; end
                  8'h08: m_rdata = shm_mapped ? {16'h0, local_id} : 32'hFFFF_FFFF;
                  default: m_rdata = 0;
               endcase
            end
         end
         if (req_valid && req_write && word) begin
            case (req_addr & 8'hFC)
               8'h00: m_enable = req_wdata;
               8'h04: nxt = req_wdata;
               8'h0C: begin m_bell_v = 1; m_bell_d = req_wdata; end
               default: ;
            endcase
         end
         if (evt_valid) nxt = {24'h0, evt_data};
         m_cause = nxt;
      end
   end

   always @(negedge clk) begin
      if (live && !done) begin
         chk(irq == ((m_cause & m_enable) != 0), {tag, " irq"}, 32'(irq),
             32'((m_cause & m_enable) != 0));
         chk(rsp_valid == m_rsp_v, {tag, " rsp_valid"}, 32'(rsp_valid), 32'(m_rsp_v));
         if (m_rsp_v) chk(rsp_rdata == m_rdata, {tag, " rsp_rdata"}, rsp_rdata, m_rdata);
         chk(bell_valid == m_bell_v, {tag, " bell_valid"}, 32'(bell_valid), 32'(m_bell_v));
         if (m_bell_v) chk(bell_data == m_bell_d, {tag, " bell_data"}, bell_data, m_bell_d);
      end
   end

   // one request (optionally with an event) for one cycle; d = response data
   task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input bit ev, input logic [7:0] evd,
                         output logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      evt_valid = ev; evt_data = evd;
      @(negedge clk);
      req_valid = 0; evt_valid = 0;
      d = rsp_rdata;
   endtask

   task automatic event_in(input logic [7:0] v);
      @(negedge clk);
      evt_valid = 1; evt_data = v;
      @(negedge clk);
      evt_valid = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      tag = "R11";
      chk(irq == 0 && rsp_valid == 0 && bell_valid == 0, "R11 reset outputs",
          {29'h0, irq, rsp_valid, bell_valid}, 0);

      tag = "R9";
      access(1, 8'h00, 2'd2, 32'h0000_00FF, 0, 0, d);
      event_in(8'h05);
      chk(irq == 1, "R9 R3 event raises irq", 32'(irq), 1);

      tag = "R5";
      access(0, 8'h04, 2'd2, 0, 0, 0, d);
      chk(d == 32'h5, "R5 cause read value", d, 32'h5);
      chk(irq == 0, "R5 irq dropped", 32'(irq), 0);

      tag = "R4";
      access(1, 8'h04, 2'd2, 32'h0000_0100, 0, 0, d);
      chk(irq == 0, "R3 masked cause", 32'(irq), 0);
      access(1, 8'h00, 2'd2, 32'h0000_01FF, 0, 0, d);
      chk(irq == 1, "R4 enable replaced", 32'(irq), 1);
      tag = "R1";
      access(0, 8'h00, 2'd2, 0, 0, 0, d);
      chk(d == 32'h1FF, "R1 enable readback", d, 32'h1FF);

      tag = "R6";
      access(1, 8'h00, 2'd0, 32'h0, 0, 0, d);
      access(1, 8'h00, 2'd1, 32'h0, 0, 0, d);
      access(0, 8'h00, 2'd2, 0, 0, 0, d);
      chk(d == 32'h1FF, "R6 narrow write ignored", d, 32'h1FF);
      access(0, 8'h04, 2'd1, 0, 0, 0, d);
      chk(d == 0, "R6 narrow read zero", d, 0);
      chk(irq == 1, "R6 narrow read no clear", 32'(irq), 1);

      tag = "R2";
      access(1, 8'h07, 2'd2, 32'h3, 0, 0, d);
      tag = "R8";
      access(0, 8'h05, 2'd2, 0, 0, 0, d);
      chk(d == 0, "R8 unaligned read zero", d, 0);
      tag = "R2";
      access(0, 8'h04, 2'd2, 0, 0, 0, d);
      chk(d == 32'h3, "R2 write low bits dropped", d, 32'h3);

      tag = "R7";
      access(0, 8'h08, 2'd2, 0, 0, 0, d);
      chk(d == 32'hFFFF_FFFF, "R7 unmapped identity", d, 32'hFFFF_FFFF);
      shm_mapped = 1; local_id = 16'h002A;
      access(0, 8'h08, 2'd2, 0, 0, 0, d);
      chk(d == 32'h2A, "R7 mapped identity", d, 32'h2A);

      tag = "R8";
      access(0, 8'h0C, 2'd2, 0, 0, 0, d);
      chk(d == 0, "R8 doorbell reads zero", d, 0);
      access(0, 8'h40, 2'd2, 0, 0, 0, d);
      chk(d == 0, "R8 undecoded zero", d, 0);

      tag = "R12";
      access(1, 8'h0C, 2'd2, 32'h0003_0001, 0, 0, d);
      chk(bell_valid == 1 && bell_data == 32'h0003_0001, "R12 doorbell strobe",
          bell_data, 32'h0003_0001);
      @(negedge clk);
      chk(bell_valid == 0, "R12 one cycle only", 32'(bell_valid), 0);
      tag = "R6";
      access(1, 8'h0C, 2'd0, 32'hFF, 0, 0, d);
      chk(bell_valid == 0, "R6 narrow doorbell ignored", 32'(bell_valid), 0);

      tag = "R10";
      access(1, 8'h04, 2'd2, 32'h11, 0, 0, d);
      access(0, 8'h04, 2'd2, 0, 1, 8'h22, d);
      chk(d == 32'h11, "R10 read sees old cause", d, 32'h11);
      access(0, 8'h04, 2'd2, 0, 0, 0, d);
      chk(d == 32'h22, "R10 event beats read-clear", d, 32'h22);
      access(1, 8'h04, 2'd2, 32'h44, 1, 8'h01, d);
      access(0, 8'h04, 2'd2, 0, 0, 0, d);
      chk(d == 32'h1, "R10 event beats write", d, 32'h1);

      tag = "R9";
      access(1, 8'h04, 2'd2, 32'hFFFF_FF00, 0, 0, d);
      event_in(8'h80);
      access(0, 8'h04, 2'd2, 0, 0, 0, d);
      chk(d == 32'h80, "R9 event zero-extended", d, 32'h80);

      tag = "R11";
      access(1, 8'h00, 2'd2, 32'h0000_ABCD, 0, 0, d);
      event_in(8'h01);
      chk(irq == 1, "R11 irq before reset", 32'(irq), 1);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      chk(irq == 0, "R11 cause cleared", 32'(irq), 0);
      access(0, 8'h00, 2'd2, 0, 0, 0, d);
      chk(d == 32'hABCD, "R11 enable retained", d, 32'hABCD);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule